// File: doc/BRIEF.md
# Serial Bit-Clock Source Detector

This block sits in front of a serial audio receiver and picks the bit clock that the receiver should use. It watches the bit-clock and frame-clock pins, both sampled in the master-clock domain. Once enough bit-clock activity appears inside one frame half, it switches to the external bit clock. When the bit clock falls silent for long enough, it falls back to a bit-clock enable made inside the block by dividing the master clock.

The internal enable is locked to the frame clock. Its divider restarts on every frame-clock transition. The divide factor comes from two selects: master-clock cycles per frame, and bits per frame. The receiver sees one bit-clock enable that is valid in either mode. It also gets a mode flag and a single-cycle pulse whenever the source changes.

Top module: `bclk_source_det`

## Requirements
- R1: While reset is asserted, and after it is released, the block is in internal mode (`ext_mode_o` = 0) with `mode_chg_o` = 0.
- R2: In internal mode, the 16th bit-clock rising edge counted within one frame-clock half puts the block into external mode within four master-clock cycles of that edge at the pin.
- R3: The edge count restarts at every frame-clock transition and saturates at 16. Fifteen rising edges in one half followed by fifteen in the next do not select external mode.
- R4: A bit-clock rising edge that reaches the detector in the same cycle as a frame-clock transition counts as the first edge of the new half.
- R5: In external mode, two frame-clock rising edges with no bit-clock rising edge between or on them return the block to internal mode. One such edge does not.
- R6: Any bit-clock rising edge clears the silence count. This includes an edge that arrives in the same cycle as a frame-clock rising edge.
- R7: `mode_chg_o` is high for exactly one master-clock cycle per mode change, in the cycle in which `ext_mode_o` shows its new value, and is low otherwise.
- R8: In external mode, `bclk_en_o` pulses once for each bit-clock rising edge on the pin.
- R9: In internal mode, `bclk_en_o` pulses every D master-clock cycles. D = F/B, where F is 128, 192, 256, 384 or 512 for `mclk_ratio_sel_i` = 0, 1, 2, 3 or 4 (5 to 7 mean 512), and B is 32, 48 or 64 for `bit_ratio_sel_i` = 0, 1 or 2 (3 means 64).
- R10: A frame-clock transition on the pin restarts the internal divider. The next internal pulse comes exactly D+2 master-clock cycles after the transition, counting the two synchronizer stages, and no pulse comes between the 3rd cycle and that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk_pin_i | input | 1 | Bit-clock pin, asynchronous |
| lrck_pin_i | input | 1 | Frame-clock pin, asynchronous |
| mclk_ratio_sel_i | input | 3 | Master-clock cycles per frame select |
| bit_ratio_sel_i | input | 2 | Bit-clock cycles per frame select (internal mode) |
| ext_mode_o | output | 1 | 1 = external bit clock in use |
| bclk_en_o | output | 1 | One-cycle enable per selected bit-clock edge |
| mode_chg_o | output | 1 | One-cycle pulse on each mode change |

## Verification
A bit-clock rising edge and a frame-clock transition can reach the detector in the same master-clock cycle. That single cycle then both restarts the edge count and supplies an edge, and it both advances and clears the silence count. The bench drives both pins on the same clock edge so that they leave the synchronizers together. It then checks the outcome at the mode flag. Fifteen more edges must be enough to enter external mode, and one later silent frame must not be enough to leave it.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic {
    MODE_INT = 1'b0,
    MODE_EXT = 1'b1
  } clk_mode_e;

  function automatic int mclk_per_frame(input logic [2:0] sel);
    case (sel)
      3'd0:    return 128;
      3'd1:    return 192;
      3'd2:    return 256;
      3'd3:    return 384;
      default: return 512;
    endcase
  endfunction

  function automatic int bits_per_frame(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32;
      2'd1:    return 48;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/bcs_sync.sv
module bcs_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin_i[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign rise_o[g] = sync_q & ~prev_q;
    assign fall_o[g] = ~sync_q & prev_q;
  end
endmodule

// File: rtl/bcs_int_div.sv
module bcs_int_div #(
  parameter int DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             align_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap   = (cnt_q >= div_i - DIV_W'(1));
  assign tick_o = wrap;

  always_comb begin
    if (align_i)   cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bcs_mode_fsm.sv
module bcs_mode_fsm
  import bcs_pkg::*;
#(
  parameter int SAT_EDGES     = 16,
  parameter int SILENT_FRAMES = 2,
  localparam int EDGE_W = $clog2(SAT_EDGES + 1),
  localparam int SIL_W  = $clog2(SILENT_FRAMES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_rise_i,
  input  logic              lrck_rise_i,
  input  logic              lrck_edge_i,
  output logic              ext_mode_o,
  output logic              mode_chg_o,
  output logic [EDGE_W-1:0] edge_cnt_o
);
  localparam logic [EDGE_W-1:0] EDGE_SAT = EDGE_W'(SAT_EDGES);
  localparam logic [SIL_W-1:0]  SIL_SAT  = SIL_W'(SILENT_FRAMES);

  clk_mode_e         mode_q, mode_d;
  logic              chg_q, chg_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic [SIL_W-1:0]  sil_q, sil_d;
  logic              enter, leave;

  always_comb begin
    // edge counter: restart per frame half, same-cycle edge opens new half
    if (lrck_edge_i)                        edge_d = sclk_rise_i ? EDGE_W'(1) : '0;
    else if (sclk_rise_i && edge_q != EDGE_SAT) edge_d = edge_q + EDGE_W'(1);
    else                                    edge_d = edge_q;

    // silence counter: frame rises with no bit-clock edge
    if (sclk_rise_i)                             sil_d = '0;
    else if (lrck_rise_i && sil_q != SIL_SAT)    sil_d = sil_q + SIL_W'(1);
    else                                         sil_d = sil_q;

    enter  = (mode_q == MODE_INT) && sclk_rise_i && (edge_d == EDGE_SAT);
    leave  = (mode_q == MODE_EXT) && (sil_d == SIL_SAT);
    mode_d = mode_q;
    if (enter)      mode_d = MODE_EXT;
    else if (leave) mode_d = MODE_INT;
    chg_d  = enter | leave;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_INT;
      chg_q  <= 1'b0;
      edge_q <= '0;
      sil_q  <= '0;
    end else begin
      mode_q <= mode_d;
      chg_q  <= chg_d;
      edge_q <= edge_d;
      sil_q  <= sil_d;
    end
  end

  assign ext_mode_o = (mode_q == MODE_EXT);
  assign mode_chg_o = chg_q;
  assign edge_cnt_o = edge_q;
endmodule

// File: rtl/bclk_source_det.sv
module bclk_source_det
  import bcs_pkg::*;
#(
  parameter int SAT_EDGES     = 16,
  parameter int SILENT_FRAMES = 2,
  parameter int DIV_W         = 5,
  localparam int EDGE_W = $clog2(SAT_EDGES + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_pin_i,
  input  logic       lrck_pin_i,
  input  logic [2:0] mclk_ratio_sel_i,
  input  logic [1:0] bit_ratio_sel_i,
  output logic       ext_mode_o,
  output logic       bclk_en_o,
  output logic       mode_chg_o
);
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(8);

  logic [1:0]       rise, fall;
  logic             sclk_rise, lrck_rise, lrck_edge;
  logic [DIV_W-1:0] div_q, div_d;
  logic             int_tick;
  logic [EDGE_W-1:0] edge_cnt;

  bcs_sync #(.W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({lrck_pin_i, sclk_pin_i}),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign sclk_rise = rise[0];
  assign lrck_rise = rise[1];
  assign lrck_edge = rise[1] | fall[1];

  // divisor registered: selects are quasi-static, keeps the divide off the tick path
  assign div_d = DIV_W'(mclk_per_frame(mclk_ratio_sel_i) / bits_per_frame(bit_ratio_sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= DIV_RST;
    else         div_q <= div_d;
  end

  bcs_int_div #(.DIV_W(DIV_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_i   (div_q),
    .align_i (lrck_edge),
    .tick_o  (int_tick)
  );

  bcs_mode_fsm #(
    .SAT_EDGES     (SAT_EDGES),
    .SILENT_FRAMES (SILENT_FRAMES)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_rise_i (sclk_rise),
    .lrck_rise_i (lrck_rise),
    .lrck_edge_i (lrck_edge),
    .ext_mode_o  (ext_mode_o),
    .mode_chg_o  (mode_chg_o),
    .edge_cnt_o  (edge_cnt)
  );

  assign bclk_en_o = ext_mode_o ? sclk_rise : int_tick;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int SAT_EDGES = 16,
  localparam int EDGE_W = $clog2(SAT_EDGES + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ext_mode_o,
  input logic              mode_chg_o,
  input logic              sclk_rise,
  input logic              lrck_rise,
  input logic [EDGE_W-1:0] edge_cnt
);
  AST_ENTER_ON_SCLK_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_mode_o) |-> $past(sclk_rise)); // R2

  AST_EDGE_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(edge_cnt) <= SAT_EDGES); // R3

  AST_LEAVE_ON_SILENT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ext_mode_o) |-> ($past(lrck_rise) && !$past(sclk_rise))); // R5

  AST_CHG_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |=> !mode_chg_o); // R7

  AST_CHG_MARKS_MODE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o == (ext_mode_o != $past(ext_mode_o))); // R7
endmodule

bind bclk_source_det bcs_checker #(.SAT_EDGES(SAT_EDGES)) u_bcs_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ext_mode_o (ext_mode_o),
  .mode_chg_o (mode_chg_o),
  .sclk_rise  (sclk_rise),
  .lrck_rise  (lrck_rise),
  .edge_cnt   (edge_cnt)
);

// File: tb/bclk_source_det_bench.sv
module bclk_source_det_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {mclk_ratio_sel, bit_ratio_sel, expected divide}
  localparam logic [12:0] VEC [NVEC] = '{
    {3'd0, 2'd0, 8'd4},  {3'd0, 2'd2, 8'd2},  {3'd2, 2'd0, 8'd8},
    {3'd2, 2'd2, 8'd4},  {3'd4, 2'd0, 8'd16}, {3'd4, 2'd2, 8'd8},
    {3'd1, 2'd1, 8'd4},  {3'd3, 2'd1, 8'd8}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       lrck = 1'b0;
  logic [2:0] msel = 3'd2;
  logic [1:0] bsel = 2'd0;
  logic       ext_mode, bclk_en, mode_chg;
  int checks = 0, errors = 0, en_cnt = 0, chg_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bclk_source_det u_bclk_source_det (
    .clk_i(clk), .rst_ni(rst_n), .sclk_pin_i(sclk), .lrck_pin_i(lrck),
    .mclk_ratio_sel_i(msel), .bit_ratio_sel_i(bsel),
    .ext_mode_o(ext_mode), .bclk_en_o(bclk_en), .mode_chg_o(mode_chg)
  );

  always @(negedge clk) if (rst_n) begin
    if (bclk_en)  en_cnt++;
    if (mode_chg) chg_cnt++;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sclk_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      step(); sclk = 1'b1; step(); step();
      sclk = 1'b0; step(); step();
    end
  endtask

  task automatic set_lrck(input logic v);
    step(); lrck = v;
    for (int i = 0; i < 4; i++) step();
  endtask

  task automatic lrck_with_sclk(input logic v);
    step(); lrck = v; sclk = 1'b1; step(); step();
    sclk = 1'b0; step(); step();
  endtask

  initial begin
    int per, k, first;
    repeat (3) step();
    check(ext_mode == 1'b0 && mode_chg == 1'b0, "R1 reset", ext_mode, 0);
    rst_n = 1'b1;
    repeat (3) step();
    check(ext_mode == 1'b0, "R1 after release", ext_mode, 0);

    // R9: internal divide for each ratio pair
    for (int v = 0; v < NVEC; v++) begin
      msel = VEC[v][12:10]; bsel = VEC[v][9:8];
      repeat (40) step();
      k = 0;
      while (!bclk_en && k < 100) begin step(); k++; end
      per = 0;
      do begin step(); per++; end while (!bclk_en && per < 100);
      check(per == int'(VEC[v][7:0]), "R9 internal period", per, int'(VEC[v][7:0]));
    end

    // R10: realign on frame-clock transition, divide 8
    msel = 3'd2; bsel = 2'd0;
    repeat (20) step();
    step(); lrck = 1'b1;
    first = 0;
    for (int i = 1; i <= 40 && first == 0; i++) begin
      step();
      if (i >= 3 && bclk_en) first = i;
    end
    check(first == 10, "R10 realign", first, 10);
    repeat (4) step();

    // R3: 15 + 15 edges across a half boundary
    sclk_pulses(15);
    set_lrck(1'b0);
    sclk_pulses(15);
    check(ext_mode == 1'b0, "R3 no entry across halves", ext_mode, 0);
    set_lrck(1'b1);

    // R2 / R7: entry on 16th edge
    chg_cnt = 0;
    sclk_pulses(15);
    check(ext_mode == 1'b0, "R2 15 edges", ext_mode, 0);
    sclk_pulses(1);
    check(ext_mode == 1'b1, "R2 16th edge", ext_mode, 1);
    check(chg_cnt == 1, "R7 entry pulse", chg_cnt, 1);

    // R8: enable follows pin edges in external mode
    en_cnt = 0;
    sclk_pulses(10);
    check(en_cnt == 10, "R8 external enables", en_cnt, 10);

    // R6: edges between silent frames keep external mode
    chg_cnt = 0;
    set_lrck(1'b0); set_lrck(1'b1);
    sclk_pulses(1);
    set_lrck(1'b0); set_lrck(1'b1);
    check(ext_mode == 1'b1, "R6 edge clears silence", ext_mode, 1);
    set_lrck(1'b0);
    lrck_with_sclk(1'b1);
    set_lrck(1'b0); set_lrck(1'b1);
    check(ext_mode == 1'b1, "R6 coincident edge clears silence", ext_mode, 1);

    // R5: one silent frame stays, two leave
    sclk_pulses(1);
    set_lrck(1'b0); set_lrck(1'b1);
    check(ext_mode == 1'b1, "R5 one silent frame", ext_mode, 1);
    set_lrck(1'b0); set_lrck(1'b1);
    check(ext_mode == 1'b0, "R5 two silent frames", ext_mode, 0);
    check(chg_cnt == 1, "R7 exit pulse", chg_cnt, 1);

    // R4: coincident edge opens the new half
    set_lrck(1'b0);
    sclk_pulses(5);
    lrck_with_sclk(1'b1);
    sclk_pulses(14);
    check(ext_mode == 1'b0, "R4 15 edges in half", ext_mode, 0);
    sclk_pulses(1);
    check(ext_mode == 1'b1, "R4 16 with coincident", ext_mode, 1);

    // R1: reset from external mode
    step(); rst_n = 1'b0;
    step();
    check(ext_mode == 1'b0 && mode_chg == 1'b0, "R1 reset from external", ext_mode, 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule